// File: doc/BRIEF.md
# Two-Level Vectored Interrupt Arbiter

This block collects interrupt requests from six sources of a small 8-bit controller core: two external lines, the overflow strobes of two timers, a serial-port request and a third timer's request. It offers the highest-ranked request to the CPU as a single request line with a 3-bit vector index. Software sets up two registers through a simple write/read port. The mask register holds one enable bit per source and a master enable. The level register marks each source as high or low priority.

When the CPU takes a request it pulses the acknowledge input. At that clock edge the block records the request's level as in service. It also clears the pending flag of that source if the source's flag clears itself. The serial and third-timer requests are plain levels held by their own logic. Software clears them there, so acknowledging them leaves them asserted. A return pulse from the CPU ends the innermost active handler.

The reset input is asynchronous and active low. Its release is synchronised internally, so the block leaves reset two clock edges after the input rises.

Top module: `irq_arbiter`

## Requirements
- R1: While reset is held, and after it is released with no writes, `irq_req` is 0 and both registers read 0x00.
- R2: Mask register (`reg_sel`=0): bit 0 = external 0, bit 1 = timer 0, bit 2 = external 1, bit 3 = timer 1, bit 4 = serial, bit 5 = timer 2, bit 7 = master enable. Bit 6 is reserved; writes to it are ignored and it reads 0. Level register (`reg_sel`=1): bits 5:0 are the per-source high-priority bits in that same source order. Bits 7:6 are reserved; writes to them are ignored and they read 0.
- R3: With the master enable at 0, `irq_req` stays 0 whatever is pending.
- R4: A pending source whose own enable bit is 0 never produces a request.
- R5: Among eligible sources of one level, the lowest source number wins. The order is external 0 (vector 0), timer 0 (1), external 1 (2), timer 1 (3), serial (4), timer 2 (5), and `irq_vec` carries that number.
- R6: Any eligible high-level source wins over every low-level source, whatever its source number.
- R7: A rising edge on `ext_in[k]` and a one-cycle pulse on `tmr_ovf[k]` each set a pending flag. The flag holds after the input drops. An external line held high sets its flag only once.
- R8: An acknowledge of vector 0, 1, 2 or 3 clears that source's pending flag at the same edge.
- R9: Serial and timer-2 requests follow `ser_irq` and `tmr2_irq` directly. An acknowledge does not clear them, and the request stays pending until the input falls.
- R10: While a low-level handler is in service, only a high-level request is offered. While a high-level handler is in service, no request is offered.
- R11: An `irq_reti` pulse clears the high-level in-service mark if it is set, and otherwise clears the low-level mark.
- R12: An `irq_ack` pulse while `irq_req` is 0 changes no state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_sel | input | 1 | Register select: 0 mask, 1 level |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data of the selected register |
| ext_in | input | 2 | External request lines, rising-edge sensitive |
| tmr_ovf | input | 2 | Timer 0 / timer 1 overflow strobes |
| ser_irq | input | 1 | Serial-port request level |
| tmr2_irq | input | 1 | Timer-2 request level (either of its two causes) |
| irq_req | output | 1 | Request to the CPU |
| irq_vec | output | 3 | Vector index of the offered request |
| irq_ack | input | 1 | CPU acknowledge pulse |
| irq_reti | input | 1 | Return-from-interrupt pulse |

## Verification
Most internal faults show up at `irq_req`/`irq_vec` in the first cycle after the faulty edge, because the request path after the flag, mask and in-service registers is combinational. A flag that is not cleared makes the same vector come back at once after a return. An in-service mark that is set wrongly hides every later request of its level, and one that is not set lets a same-level request through during a handler. Register faults appear on `reg_rdata` at the next read, and through masking at the next request.

// File: rtl/irq_pkg.sv
`timescale 1ns/1ps
package irq_pkg;
  localparam int NSRC   = 6;
  localparam int VEC_W  = $clog2(NSRC);
  localparam int NAUTO  = 4;
  localparam int REG_W  = 8;
  localparam int GLB_BIT = REG_W - 1;
  typedef logic [NSRC-1:0] src_vec_t;
  typedef logic [VEC_W-1:0] vec_t;
endpackage

// File: rtl/irq_rst_sync.sv
`timescale 1ns/1ps
module irq_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [STAGES-1:0] sh_q;
  logic [STAGES-1:0] sh_d;

  always_comb sh_d = {sh_q[STAGES-2:0], 1'b1};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sh_q <= '0;
    else        sh_q <= sh_d;
  end

  assign rst_sync_n = sh_q[STAGES-1];
endmodule

// File: rtl/irq_regs.sv
`timescale 1ns/1ps
module irq_regs
  import irq_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr,
  input  logic             sel,
  input  logic [REG_W-1:0] wdata,
  output logic [REG_W-1:0] rdata,
  output src_vec_t         en_src,
  output logic             en_glb,
  output src_vec_t         lvl_hi
);
  src_vec_t en_q, en_d, lv_q, lv_d;
  logic     glb_q, glb_d;
  logic     en_we, lv_we;

  assign en_we = wr && !sel;
  assign lv_we = wr && sel;

  always_comb begin
    en_d  = en_q;
    glb_d = glb_q;
    lv_d  = lv_q;
    if (en_we) begin
      en_d  = wdata[NSRC-1:0];
      glb_d = wdata[GLB_BIT];
    end
    if (lv_we) lv_d = wdata[NSRC-1:0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q  <= '0;
      glb_q <= 1'b0;
      lv_q  <= '0;
    end else begin
      en_q  <= en_d;
      glb_q <= glb_d;
      lv_q  <= lv_d;
    end
  end

  always_comb begin
    rdata = '0;
    if (sel) begin
      rdata[NSRC-1:0] = lv_q;
    end else begin
      rdata[NSRC-1:0] = en_q;
      rdata[GLB_BIT]  = glb_q;
    end
  end

  assign en_src = en_q;
  assign en_glb = glb_q;
  assign lvl_hi = lv_q;

  AST_MASK_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    en_we |=> (en_glb == $past(wdata[GLB_BIT]))); // R2
endmodule

// File: rtl/irq_flags.sv
`timescale 1ns/1ps
module irq_flags
  import irq_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic [1:0] ext_in,
  input  logic [1:0] tmr_ovf,
  input  logic       ser_lvl,
  input  logic       t2_lvl,
  input  logic       clr_en,
  input  vec_t       clr_idx,
  output src_vec_t   pend
);
  logic [1:0]       prev_q, prev_d;
  logic [NAUTO-1:0] set_v;
  logic [NAUTO-1:0] flag_q, flag_d;

  always_comb begin
    prev_d   = ext_in;
    set_v[0] = ext_in[0] && !prev_q[0];
    set_v[1] = tmr_ovf[0];
    set_v[2] = ext_in[1] && !prev_q[1];
    set_v[3] = tmr_ovf[1];
  end

  for (genvar i = 0; i < NAUTO; i++) begin : g_flag
    always_comb
      flag_d[i] = set_v[i] || (flag_q[i] && !(clr_en && clr_idx == vec_t'(i)));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_q <= '0;
      flag_q <= '0;
    end else begin
      prev_q <= prev_d;
      flag_q <= flag_d;
    end
  end

  assign pend = {t2_lvl, ser_lvl, flag_q};

  AST_ACK_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_en && clr_idx == vec_t'(1) && !tmr_ovf[0]) |=> !pend[1]); // R8
  AST_FLAG_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (pend[3] && !(clr_en && clr_idx == vec_t'(3))) |=> pend[3]); // R7
endmodule

// File: rtl/irq_pick.sv
`timescale 1ns/1ps
module irq_pick
  import irq_pkg::*;
(
  input  src_vec_t pend,
  input  src_vec_t en_src,
  input  logic     en_glb,
  input  src_vec_t lvl_hi,
  input  logic     ins_hi,
  input  logic     ins_lo,
  output logic     req,
  output vec_t     vec,
  output logic     req_lvl
);
  src_vec_t elig, hi_v, lo_v;
  vec_t     hi_idx, lo_idx;

  always_comb begin
    elig = pend & en_src & {NSRC{en_glb}};
    hi_v = elig & lvl_hi;
    lo_v = elig & ~lvl_hi;
    hi_idx = '0;
    lo_idx = '0;
    for (int i = NSRC - 1; i >= 0; i--) begin
      if (hi_v[i]) hi_idx = vec_t'(i);
      if (lo_v[i]) lo_idx = vec_t'(i);
    end
  end

  always_comb begin
    req     = 1'b0;
    vec     = '0;
    req_lvl = 1'b0;
    if ((|hi_v) && !ins_hi) begin
      req     = 1'b1;
      vec     = hi_idx;
      req_lvl = 1'b1;
    end else if ((|lo_v) && !ins_hi && !ins_lo) begin
      req     = 1'b1;
      vec     = lo_idx;
    end
  end
endmodule

// File: rtl/irq_service.sv
`timescale 1ns/1ps
module irq_service (
  input  logic clk,
  input  logic rst_n,
  input  logic take,
  input  logic take_lvl,
  input  logic reti,
  output logic ins_hi,
  output logic ins_lo
);
  logic hi_q, hi_d, lo_q, lo_d;

  always_comb begin
    hi_d = hi_q;
    lo_d = lo_q;
    if (reti) begin
      if (hi_q) hi_d = 1'b0;
      else      lo_d = 1'b0;
    end
    if (take) begin
      if (take_lvl) hi_d = 1'b1;
      else          lo_d = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hi_q <= 1'b0;
      lo_q <= 1'b0;
    end else begin
      hi_q <= hi_d;
      lo_q <= lo_d;
    end
  end

  assign ins_hi = hi_q;
  assign ins_lo = lo_q;

  AST_RETI_TOP: assert property (@(posedge clk) disable iff (!rst_n)
    (reti && !take && hi_q) |=> (!ins_hi && ins_lo == $past(lo_q))); // R11
  AST_IDLE_ACK: assert property (@(posedge clk) disable iff (!rst_n)
    (!take && !reti) |=> (ins_hi == $past(hi_q) && ins_lo == $past(lo_q))); // R12
endmodule

// File: rtl/irq_arbiter.sv
`timescale 1ns/1ps
module irq_arbiter
  import irq_pkg::*;
#(
  parameter int RST_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             reg_wr,
  input  logic             reg_sel,
  input  logic [REG_W-1:0] reg_wdata,
  output logic [REG_W-1:0] reg_rdata,
  input  logic [1:0]       ext_in,
  input  logic [1:0]       tmr_ovf,
  input  logic             ser_irq,
  input  logic             tmr2_irq,
  output logic             irq_req,
  output logic [VEC_W-1:0] irq_vec,
  input  logic             irq_ack,
  input  logic             irq_reti
);
  logic     rst_q_n;
  src_vec_t en_src, lvl_hi, pend;
  logic     en_glb, ins_hi, ins_lo, req_lvl, take;
  vec_t     vec;

  irq_rst_sync #(.STAGES(RST_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .rst_sync_n(rst_q_n));

  irq_regs u_regs (
    .clk(clk), .rst_n(rst_q_n), .wr(reg_wr), .sel(reg_sel),
    .wdata(reg_wdata), .rdata(reg_rdata),
    .en_src(en_src), .en_glb(en_glb), .lvl_hi(lvl_hi));

  assign take = irq_ack && irq_req;

  irq_flags u_flags (
    .clk(clk), .rst_n(rst_q_n), .ext_in(ext_in), .tmr_ovf(tmr_ovf),
    .ser_lvl(ser_irq), .t2_lvl(tmr2_irq),
    .clr_en(take), .clr_idx(vec), .pend(pend));

  irq_pick u_pick (
    .pend(pend), .en_src(en_src), .en_glb(en_glb), .lvl_hi(lvl_hi),
    .ins_hi(ins_hi), .ins_lo(ins_lo),
    .req(irq_req), .vec(vec), .req_lvl(req_lvl));

  irq_service u_svc (
    .clk(clk), .rst_n(rst_q_n), .take(take), .take_lvl(req_lvl),
    .reti(irq_reti), .ins_hi(ins_hi), .ins_lo(ins_lo));

  assign irq_vec = vec;

  AST_GLOBAL_GATE: assert property (@(posedge clk) disable iff (!rst_q_n)
    !en_glb |-> !irq_req); // R3
  AST_VEC_VALID: assert property (@(posedge clk) disable iff (!rst_q_n)
    irq_req |-> (pend[vec] && en_src[vec])); // R4
  AST_HI_BLOCKS: assert property (@(posedge clk) disable iff (!rst_q_n)
    ins_hi |-> !irq_req); // R10
  AST_LOW_WAITS: assert property (@(posedge clk) disable iff (!rst_q_n)
    (ins_lo && irq_req) |-> lvl_hi[vec]); // R10
endmodule

// File: tb/irq_arbiter_test.sv
`timescale 1ns/1ps
module irq_arbiter_test;
  logic       clk = 1'b0;
  logic       rst_n;
  logic       reg_wr, reg_sel;
  logic [7:0] reg_wdata, reg_rdata;
  logic [1:0] ext_in, tmr_ovf;
  logic       ser_irq, tmr2_irq, irq_req, irq_ack, irq_reti;
  logic [2:0] irq_vec;
  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #5 clk = ~clk;

  irq_arbiter uut (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_sel(reg_sel),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .ext_in(ext_in),
    .tmr_ovf(tmr_ovf), .ser_irq(ser_irq), .tmr2_irq(tmr2_irq),
    .irq_req(irq_req), .irq_vec(irq_vec), .irq_ack(irq_ack),
    .irq_reti(irq_reti));

  // row: mask[25:18] level[17:10] sources[9:4] exp_req[3] exp_vec[2:0]
  localparam logic [25:0] TAB [10] = '{
    {8'h3F, 8'h00, 6'h3F, 1'b0, 3'd0},
    {8'hBF, 8'h00, 6'h3F, 1'b1, 3'd0},
    {8'hBF, 8'h00, 6'h3E, 1'b1, 3'd1},
    {8'hBF, 8'h00, 6'h30, 1'b1, 3'd4},
    {8'hBF, 8'h00, 6'h20, 1'b1, 3'd5},
    {8'hBF, 8'h20, 6'h3F, 1'b1, 3'd5},
    {8'hBF, 8'h08, 6'h0F, 1'b1, 3'd3},
    {8'hBE, 8'h00, 6'h01, 1'b0, 3'd0},
    {8'hBD, 8'h00, 6'h03, 1'b1, 3'd0},
    {8'h8C, 8'h00, 6'h07, 1'b1, 3'd2}
  };

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic chk_req(input string tag, input bit r, input int v);
    chk({tag, " req"}, int'(irq_req), int'(r));
    if (r) chk({tag, " vec"}, int'(irq_vec), v);
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0; reg_wr = 0; reg_sel = 0; reg_wdata = 0;
    ext_in = 0; tmr_ovf = 0; ser_irq = 0; tmr2_irq = 0;
    irq_ack = 0; irq_reti = 0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
  endtask

  task automatic wr_reg(input bit sel, input logic [7:0] d);
    reg_wr = 1; reg_sel = sel; reg_wdata = d;
    @(negedge clk);
    reg_wr = 0;
  endtask

  task automatic pulse_ack();
    irq_ack = 1; @(negedge clk); irq_ack = 0;
  endtask

  task automatic pulse_reti();
    irq_reti = 1; @(negedge clk); irq_reti = 0;
  endtask

  task automatic pulse_tmr(input int k);
    tmr_ovf[k] = 1; @(negedge clk); tmr_ovf[k] = 0;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    // R1: state during and after reset
    @(negedge clk);
    rst_n = 1'b0; reg_wr = 0; reg_sel = 0; reg_wdata = 0;
    ext_in = 0; tmr_ovf = 0; ser_irq = 0; tmr2_irq = 0;
    irq_ack = 0; irq_reti = 0;
    @(negedge clk);
    chk("R1 req in reset", int'(irq_req), 0);
    chk("R1 mask in reset", int'(reg_rdata), 0);
    do_reset();
    chk("R1 req after reset", int'(irq_req), 0);
    reg_sel = 1; #1;
    chk("R1 level after reset", int'(reg_rdata), 0);
    reg_sel = 0;

    // R3 R4 R5 R6: vector table
    for (int i = 0; i < 10; i++) begin
      do_reset();
      wr_reg(1'b0, TAB[i][25:18]);
      wr_reg(1'b1, TAB[i][17:10]);
      ext_in   = {TAB[i][6], TAB[i][4]};
      tmr_ovf  = {TAB[i][7], TAB[i][5]};
      ser_irq  = TAB[i][8];
      tmr2_irq = TAB[i][9];
      @(negedge clk);
      ext_in = 0; tmr_ovf = 0;
      @(negedge clk);
      chk_req($sformatf("R3 R4 R5 R6 row %0d", i), TAB[i][3], int'(TAB[i][2:0]));
    end

    // R2: reserved bits
    do_reset();
    wr_reg(1'b0, 8'hFF);
    reg_sel = 0; #1;
    chk("R2 mask readback", int'(reg_rdata), 'hBF);
    wr_reg(1'b1, 8'hFF);
    reg_sel = 1; #1;
    chk("R2 level readback", int'(reg_rdata), 'h3F);
    reg_sel = 0;

    // R12 then R7 R8: ack without request, timer flag hold and clear
    do_reset();
    wr_reg(1'b0, 8'h82);
    pulse_ack();
    pulse_tmr(0);
    repeat (3) @(negedge clk);
    chk_req("R12 R7 timer flag held", 1'b1, 1);
    pulse_ack();
    chk_req("R8 ack clears timer flag", 1'b0, 0);
    pulse_reti();
    chk_req("R8 no return of cleared flag", 1'b0, 0);

    // R7 R8: external edge sensitivity
    do_reset();
    wr_reg(1'b0, 8'h81);
    ext_in[0] = 1; @(negedge clk);
    chk_req("R7 external edge", 1'b1, 0);
    pulse_ack();
    pulse_reti();
    chk_req("R7 R8 held line no new flag", 1'b0, 0);
    ext_in[0] = 0; @(negedge clk);
    ext_in[0] = 1; @(negedge clk);
    chk_req("R7 second edge", 1'b1, 0);

    // R9: level sources not cleared by ack
    do_reset();
    wr_reg(1'b0, 8'h90);
    ser_irq = 1; @(negedge clk);
    chk_req("R9 serial level", 1'b1, 4);
    pulse_ack();
    chk_req("R10 same level waits", 1'b0, 0);
    pulse_reti();
    chk_req("R9 serial still pending", 1'b1, 4);
    ser_irq = 0; @(negedge clk);
    chk_req("R9 serial drops", 1'b0, 0);

    // R10 R11: nesting
    do_reset();
    wr_reg(1'b0, 8'h8B);
    wr_reg(1'b1, 8'h08);
    pulse_tmr(0);
    chk_req("R10 low request", 1'b1, 1);
    pulse_ack();
    ext_in[0] = 1; @(negedge clk);
    ext_in[0] = 0;
    chk_req("R10 low waits under low", 1'b0, 0);
    pulse_tmr(1);
    chk_req("R10 high preempts", 1'b1, 3);
    pulse_ack();
    chk_req("R10 nothing under high", 1'b0, 0);
    pulse_reti();
    chk_req("R11 first return keeps low", 1'b0, 0);
    pulse_reti();
    chk_req("R11 second return frees low", 1'b1, 0);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule